// File: doc/BRIEF.md
# Instruction Address Patch Comparator

This block holds a bank of address comparators that watch the addresses of instruction fetches and literal (data constant) loads. Each comparator carries a word address, a two-bit action code and an enable of its own. A single control bit turns the whole bank on or off. When an enabled comparator sees its address, the block does one of two things:

- It redirects the access to a word slot in a remap region.
- It raises a breakpoint request with a mask that names the halfwords to break on.

The default build has eight comparators. The first six are instruction comparators: they see only instruction fetches and may use any action. The last two are literal comparators: they see only literal loads and always remap.

Software programs the bank through a simple word-indexed register port, which has a synchronous write and a combinational read. Word index 0 is the control register, whose bit 0 is the global enable. Word index 1 is the remap base, which holds bits 31:5 of the base address. Word index 2+k is comparator k. The match result appears at the outputs one clock after the access address is presented, and it lasts exactly one cycle for each presented access.

Top module: `patch_unit`

## Requirements
- R1: After reset the global enable and every comparator enable read back as 0, and no access produces a remap or a breakpoint until both enables have been written.
- R2: A comparator register keeps the action code in bits 31:30, the compare address in bits 28:2 and the enable in bit 0. Bits 29 and 1 always read as 0, and writing ones to them has no effect.
- R3: Only bits 28:2 of the access address take part in the compare. Bits 31:29 and 1:0 of the access address do not affect whether it matches.
- R4: A comparator fires only while its own enable (bit 0) and the global enable (control bit 0) are both 1.
- R5: A hit with action 00 asserts remap_valid. remap_addr is then the base register's bits 31:5, followed by the 3-bit comparator index, followed by 2'b00; this is the base plus 4 times the index.
- R6: On an instruction comparator, action 01 gives bkpt_req with bkpt_mask 01 (lower halfword), action 10 gives mask 10 (upper halfword) and action 11 gives mask 11 (both). None of these codes causes a remap.
- R7: A literal comparator treats any action code as 00, so a hit on it always remaps and never raises a breakpoint.
- R8: Instruction comparators match only when acc_literal is 0. Literal comparators match only when acc_literal is 1.
- R9: When several comparators hit the same access, the lowest-numbered one decides the action and the remap slot.
- R10: The outputs for an access sampled at a clock edge appear after that edge and hold for one cycle. Back-to-back accesses give back-to-back results. A cycle without acc_valid leaves every output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| acc_valid | input | 1 | Access address is valid this cycle |
| acc_literal | input | 1 | 1 for a literal load, 0 for an instruction fetch |
| acc_addr | input | 32 | Access byte address |
| remap_valid | output | 1 | Access is redirected |
| remap_addr | output | 32 | Redirected word address |
| bkpt_req | output | 1 | Breakpoint request |
| bkpt_mask | output | 2 | Halfwords to break on: bit 0 lower, bit 1 upper |

## Verification
The accesses are chosen so that each one separates a specific cause of the result:

- Exact addresses aimed at each comparator tell the four action codes apart, and show that the remap slot follows the comparator index.
- An address with the ignored upper and lower bits flipped shows which bits take part in the compare.
- The same address sent as a fetch and as a literal load shows that the two comparator groups are kept apart.
- A literal comparator programmed with a breakpoint code shows that its action is forced to remap.
- Two comparators holding one address show which one wins.
- Accesses made with each enable cleared, and back-to-back accesses, show the enable gating and the one-cycle pulse timing.

// File: rtl/patch_pkg.sv
package patch_pkg;

    typedef enum logic [1:0] {
        ACT_REMAP   = 2'b00,
        ACT_BK_LO   = 2'b01,
        ACT_BK_HI   = 2'b10,
        ACT_BK_BOTH = 2'b11
    } act_e;

    // One comparator: action, word address bits 28:2, enable
    typedef struct packed {
        act_e        act;
        logic [26:0] cmp;
        logic        en;
    } cmp_slot_t;

    localparam int CFG_CTRL = 0;
    localparam int CFG_BASE = 1;
    localparam int CFG_CMP0 = 2;

endpackage

// File: rtl/patch_cfg_regs.sv
module patch_cfg_regs
    import patch_pkg::*;
#(
    parameter int N_CMP    = 8,
    parameter int IDX_W    = 4,
    parameter int SLOT_LSB = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [IDX_W-1:0]           addr,
    input  logic [31:0]                wdata,
    output logic [31:0]                rdata,
    output logic                       glob_en,
    output logic [31-SLOT_LSB:0]       base,
    output cmp_slot_t [N_CMP-1:0]      slots
);
    localparam int BASE_W = 32 - SLOT_LSB;

    typedef struct packed {
        logic                  glob_en;
        logic [BASE_W-1:0]     base;
        cmp_slot_t [N_CMP-1:0] slot;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        rdata  = '0;
        if (we) begin
            if (addr == IDX_W'(CFG_CTRL)) regs_d.glob_en = wdata[0];
            if (addr == IDX_W'(CFG_BASE)) regs_d.base    = wdata[31:SLOT_LSB];
            for (int i = 0; i < N_CMP; i++) begin
                if (addr == IDX_W'(CFG_CMP0 + i)) begin
                    regs_d.slot[i].act = act_e'(wdata[31:30]);
                    regs_d.slot[i].cmp = wdata[28:2];
                    regs_d.slot[i].en  = wdata[0];
                end
            end
        end
        if (addr == IDX_W'(CFG_CTRL)) rdata = {31'd0, regs_q.glob_en};
        if (addr == IDX_W'(CFG_BASE)) rdata = {regs_q.base, {SLOT_LSB{1'b0}}};
        for (int i = 0; i < N_CMP; i++) begin
            if (addr == IDX_W'(CFG_CMP0 + i))
                rdata = {regs_q.slot[i].act, 1'b0, regs_q.slot[i].cmp,
                         1'b0, regs_q.slot[i].en};
        end
    end

    // Only the enables have a defined reset value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.glob_en <= 1'b0;
            for (int i = 0; i < N_CMP; i++) regs_q.slot[i].en <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign glob_en = regs_q.glob_en;
    assign base    = regs_q.base;
    assign slots   = regs_q.slot;

endmodule

// File: rtl/patch_cmp_bank.sv
module patch_cmp_bank
    import patch_pkg::*;
#(
    parameter int N_INSTR = 6,
    parameter int N_LIT   = 2,
    parameter int SLOT_W  = 3
) (
    input  cmp_slot_t [N_INSTR+N_LIT-1:0] slots,
    input  logic                          glob_en,
    input  logic                          acc_valid,
    input  logic                          acc_literal,
    input  logic [31:0]                   acc_addr,
    output logic                          hit,
    output logic [SLOT_W-1:0]             hit_idx,
    output act_e                          hit_act
);
    localparam int N_CMP = N_INSTR + N_LIT;

    logic [N_CMP-1:0] match;
    act_e             eff_act [N_CMP];

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        localparam bit IS_LIT = (g >= N_INSTR);
        assign match[g] = slots[g].en && glob_en && acc_valid
                       && (acc_literal == IS_LIT)
                       && (acc_addr[28:2] == slots[g].cmp);
        if (IS_LIT) begin : g_lit
            assign eff_act[g] = ACT_REMAP;
        end else begin : g_ins
            assign eff_act[g] = slots[g].act;
        end
    end

    // Lowest index wins: scan from the top so the lowest overwrites last
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        hit_act = ACT_REMAP;
        for (int i = N_CMP - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = SLOT_W'(i);
                hit_act = eff_act[i];
            end
        end
    end

endmodule

// File: rtl/patch_unit.sv
module patch_unit
    import patch_pkg::*;
#(
    parameter int N_INSTR = 6,
    parameter int N_LIT   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [3:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        acc_valid,
    input  logic        acc_literal,
    input  logic [31:0] acc_addr,
    output logic        remap_valid,
    output logic [31:0] remap_addr,
    output logic        bkpt_req,
    output logic [1:0]  bkpt_mask
);
    localparam int N_CMP    = N_INSTR + N_LIT;
    localparam int SLOT_W   = $clog2(N_CMP);
    localparam int SLOT_LSB = SLOT_W + 2;
    localparam int BASE_W   = 32 - SLOT_LSB;
    localparam int IDX_W    = 4;

    typedef struct packed {
        logic        remap;
        logic [31:0] raddr;
        logic        bkpt;
        logic [1:0]  mask;
    } out_t;

    logic                  glob_en_w;
    logic [BASE_W-1:0]     base_w;
    cmp_slot_t [N_CMP-1:0] slots_w;
    logic                  hit_w;
    logic [SLOT_W-1:0]     hit_idx_w;
    act_e                  hit_act_w;
    out_t                  out_d, out_q;

    patch_cfg_regs #(.N_CMP(N_CMP), .IDX_W(IDX_W), .SLOT_LSB(SLOT_LSB)) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .glob_en(glob_en_w),
        .base   (base_w),
        .slots  (slots_w)
    );

    patch_cmp_bank #(.N_INSTR(N_INSTR), .N_LIT(N_LIT), .SLOT_W(SLOT_W)) i_bank (
        .slots      (slots_w),
        .glob_en    (glob_en_w),
        .acc_valid  (acc_valid),
        .acc_literal(acc_literal),
        .acc_addr   (acc_addr),
        .hit        (hit_w),
        .hit_idx    (hit_idx_w),
        .hit_act    (hit_act_w)
    );

    always_comb begin
        out_d = '0;
        if (hit_w) begin
            if (hit_act_w == ACT_REMAP) begin
                out_d.remap = 1'b1;
                out_d.raddr = {base_w, hit_idx_w, 2'b00};
            end else begin
                out_d.bkpt = 1'b1;
                out_d.mask = hit_act_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign remap_valid = out_q.remap;
    assign remap_addr  = out_q.raddr;
    assign bkpt_req    = out_q.bkpt;
    assign bkpt_mask   = out_q.mask;

endmodule

// File: rtl/patch_unit_chk.sv
module patch_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_literal,
    input logic        glob_en,
    input logic        remap_valid,
    input logic [31:0] remap_addr,
    input logic        bkpt_req,
    input logic [1:0]  bkpt_mask
);
    // R6
    remap_xor_bkpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(remap_valid && bkpt_req));

    // R10
    result_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (remap_valid || bkpt_req) |-> $past(acc_valid));

    // R4
    result_needs_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (remap_valid || bkpt_req) |-> $past(glob_en));

    // R6
    bkpt_mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_req |-> (bkpt_mask != 2'b00));

    // R7
    literal_never_bkpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_req |-> !$past(acc_literal));

    // R5
    remap_word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remap_valid |-> (remap_addr[1:0] == 2'b00));

    // R10
    idle_outputs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !remap_valid |-> (remap_addr == 32'd0));

endmodule

bind patch_unit patch_unit_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_literal(acc_literal),
    .glob_en    (glob_en_w),
    .remap_valid(remap_valid),
    .remap_addr (remap_addr),
    .bkpt_req   (bkpt_req),
    .bkpt_mask  (bkpt_mask)
);

// File: tb/test_patch_unit.sv
module test_patch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic        acc_literal = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        remap_valid;
    logic [31:0] remap_addr;
    logic        bkpt_req;
    logic [1:0]  bkpt_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    patch_unit i_patch_unit (.*);

    typedef struct {
        bit          remap;
        logic [31:0] raddr;
        bit          bkpt;
        logic [1:0]  mask;
        string       tag;
    } exp_t;

    exp_t sb[$];
    bit   pend = 1'b0;

    always @(posedge clk) pend <= acc_valid;

    // Monitor: compare the result of each sampled access
    always @(negedge clk) begin
        if (pend) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R10: unexpected result, queue empty");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (remap_valid !== e.remap || bkpt_req !== e.bkpt ||
                    remap_addr !== e.raddr || bkpt_mask !== e.mask) begin
                    errors++;
                    $display("FAIL %s: got remap=%0b addr=%h bkpt=%0b mask=%b, exp remap=%0b addr=%h bkpt=%0b mask=%b",
                             e.tag, remap_valid, remap_addr, bkpt_req, bkpt_mask,
                             e.remap, e.raddr, e.bkpt, e.mask);
                end
            end
        end
    end

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_check(input logic [3:0] a, input logic [31:0] exp,
                             input logic [31:0] msk, input string tag);
        cfg_addr = a;
        #1;
        checks++;
        if ((cfg_rdata & msk) !== (exp & msk)) begin
            errors++;
            $display("FAIL %s: reg %0d read %h exp %h", tag, a, cfg_rdata & msk, exp & msk);
        end
    endtask

    // Driver: present one access and queue its expected result
    task automatic access(input logic [31:0] a, input bit lit, input int kind,
                          input logic [31:0] ra, input logic [1:0] m, input string tag);
        exp_t e;
        e.remap = (kind == 1);
        e.raddr = (kind == 1) ? ra : 32'd0;
        e.bkpt  = (kind == 2);
        e.mask  = (kind == 2) ? m : 2'b00;
        e.tag   = tag;
        sb.push_back(e);
        acc_valid = 1'b1; acc_literal = lit; acc_addr = a;
        @(negedge clk);
    endtask

    task automatic idle();
        acc_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (remap_valid !== 1'b0 || bkpt_req !== 1'b0) begin
            errors++;
            $display("FAIL R10: output active without access remap=%0b bkpt=%0b exp 0 0",
                     remap_valid, bkpt_req);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        cfg_check(4'd0, 32'd0, 32'h1, "R1");
        for (int k = 0; k < 8; k++) cfg_check(4'(2 + k), 32'd0, 32'h1, "R1");
        access(32'h1000, 0, 0, 0, 0, "R1");
        idle();

        cfg_write(4'd1, 32'h2000_0000);
        cfg_write(4'd2, 32'h0000_1001); // c0 remap 0x1000
        cfg_write(4'd3, 32'h4000_1005); // c1 lower 0x1004
        cfg_write(4'd4, 32'h8000_1009); // c2 upper 0x1008
        cfg_write(4'd5, 32'hC000_100D); // c3 both  0x100C
        cfg_write(4'd6, 32'hC000_1001); // c4 both  0x1000 (loses to c0)
        // R2 reserved bits read zero
        cfg_write(4'd7, 32'hFFFF_FFFE);
        cfg_check(4'd7, 32'hDFFF_FFFC, 32'hFFFF_FFFF, "R2");
        cfg_write(4'd7, 32'h0000_1010); // c5 disabled 0x1010
        cfg_check(4'd3, 32'h4000_1005, 32'hFFFF_FFFF, "R2");
        cfg_write(4'd8, 32'hC000_2001); // c6 literal, bkpt code ignored
        cfg_write(4'd9, 32'h0000_1001); // c7 literal 0x1000
        cfg_check(4'd1, 32'h2000_0000, 32'hFFFF_FFFF, "R5");

        // R4 global enable still off
        access(32'h1000, 0, 0, 0, 0, "R4");
        idle();
        cfg_write(4'd0, 32'h1);
        cfg_check(4'd0, 32'h1, 32'hFFFF_FFFF, "R4");

        access(32'h1000, 0, 1, 32'h2000_0000, 0, "R9");
        access(32'hE000_1003, 0, 1, 32'h2000_0000, 0, "R3");
        access(32'h1004, 0, 2, 0, 2'b01, "R6");
        access(32'h1008, 0, 2, 0, 2'b10, "R6");
        access(32'h100C, 0, 2, 0, 2'b11, "R6");
        idle();
        access(32'h1010, 0, 0, 0, 0, "R4");
        access(32'h1014, 0, 0, 0, 0, "R3");
        access(32'h1004, 0, 2, 0, 2'b01, "R10");
        idle();
        access(32'h2000, 1, 1, 32'h2000_0018, 0, "R7");
        access(32'h1000, 1, 1, 32'h2000_001C, 0, "R8");
        access(32'h2000, 0, 0, 0, 0, "R8");
        access(32'h1004, 1, 0, 0, 0, "R8");
        idle();
        cfg_write(4'd0, 32'h0);
        access(32'h1000, 0, 0, 0, 0, "R4");
        idle();
        idle();

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R10: %0d results missing, exp 0", sb.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule